// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a fresh 4-bit allocation tag for a 64-bit pointer each time it is asked to. The choice uses two pieces of state that the caller keeps: a 16-bit pseudo-random seed and a 4-bit start tag. On each request the seed goes through four steps of a linear feedback shift register. The four feedback bits form a random offset. That offset is not used as the tag itself. It is the number of times the generator moves forward through the tag values that are still allowed, beginning at the start tag.

The set of forbidden tags is the union of a per-request mask and a global mask. The result comes back in two forms: the pointer with the new tag written into its tag field, and a packed state word that holds the chosen tag and the advanced seed. The caller writes that word back into its state register, and the next request draws from it. Results are registered, and a one-cycle done strobe marks each one.

Top module: `tag_randomizer`

## Requirements
- R1: The forbidden set is the bitwise OR of `req_excl_i` and `glob_excl_i`. Bit n set forbids tag n. When at least one tag is allowed, the chosen tag is never forbidden.
- R2: One LFSR step computes fb = s[5]^s[3]^s[2]^s[0], and the new seed is {fb, s[15:1]}. Four steps run per request. The fb of step k (k = 0..3) is bit k of the offset.
- R3: `state_o` holds the chosen tag in bits [3:0], zero in bits [7:4] and the seed after four steps in bits [23:8]. Bits [3:0] of `state_o` equal the tag in `ptr_o`.
- R4: When all 16 tags are forbidden, the tag is 0 and the seed still advances.
- R5: With an offset of zero, the tag is the first allowed value at or after the start tag, counting upward mod 16.
- R6: With an offset of N > 0, the generator moves forward N times from the start tag. Each move increments mod 16 at least once and stops on an allowed value. The start tag itself is not checked first.
- R7: When `rand_mode_i` is 1 and the incoming seed is zero, the seed 16'h0001 is used in its place before stepping. When `rand_mode_i` is 0, a zero seed is used as it is: it stays zero and gives an offset of zero.
- R8: `ptr_o` is `ptr_i` with bits [59:56] replaced by the tag. Every other bit is passed through unchanged.
- R9: A request sampled on a clock edge raises `done_o` for exactly the following cycle, together with the new outputs. The outputs hold their values while no request arrives.
- R10: After reset, `done_o`, `ptr_o` and `state_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one tag per cycle it is high |
| ptr_i | input | 64 | Pointer to receive the tag |
| req_excl_i | input | 16 | Per-request forbidden-tag mask |
| glob_excl_i | input | 16 | Global forbidden-tag mask |
| rand_mode_i | input | 1 | Random mode: replaces a zero seed before stepping |
| start_i | input | 4 | Current start tag |
| seed_i | input | 16 | Current LFSR seed |
| ptr_o | output | 64 | Pointer with the new tag inserted |
| state_o | output | 24 | Updated state: tag [3:0], seed [23:8] |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The zero-offset path is the hardest case to reach from the ports. Almost every seed yields at least one non-zero feedback bit, so a plain request nearly always takes the stepping path. The stimulus reaches the zero-offset path by sending a zero seed with random mode off. It then pairs that with forbidden runs that wrap past 15 to 0, which tests the "at or after start" rule apart from the stepping rule. The zero-seed replacement is reached by the same zero seed with random mode on. The all-forbidden case is forced through the global mask alone, so that the union is also exercised.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // Feedback taps: seed bits 5, 3, 2 and 0.
   localparam logic [15:0] RTG_TAPS_DEFAULT = 16'h002D;
   // Non-zero seed used in place of a zero seed in random mode.
   localparam logic [15:0] RTG_SUB_DEFAULT  = 16'h0001;
endpackage

// File: rtl/rtg_lfsr.sv
module rtg_lfsr #(
   parameter int unsigned        SEED_W = 16,
   parameter int unsigned        STEPS  = 4,
   parameter logic [SEED_W-1:0]  TAPS   = rtg_pkg::RTG_TAPS_DEFAULT
) (
   input  logic [SEED_W-1:0] seed_i,
   output logic [SEED_W-1:0] seed_o,
   output logic [STEPS-1:0]  bits_o
);
   logic [SEED_W-1:0] chain [STEPS+1];

   assign chain[0] = seed_i;

   for (genvar g = 0; g < STEPS; g++) begin : g_step
      assign bits_o[g]    = ^(chain[g] & TAPS);
      assign chain[g+1]   = {bits_o[g], chain[g][SEED_W-1:1]};
   end

   assign seed_o = chain[STEPS];
endmodule

// File: rtl/rtg_pick.sv
module rtg_pick #(
   parameter int unsigned TAG_W = 4,
   parameter int unsigned OFF_W = 4
) (
   input  logic [TAG_W-1:0]        start_i,
   input  logic [OFF_W-1:0]        offset_i,
   input  logic [(1<<TAG_W)-1:0]   excl_i,
   output logic [TAG_W-1:0]        tag_o
);
   localparam int unsigned NUM_TAGS = 1 << TAG_W;
   localparam int unsigned MAX_OFF  = (1 << OFF_W) - 1;

   // First allowed value strictly after t (wraps); t+NUM if none.
   function automatic logic [TAG_W-1:0] next_ok(input logic [TAG_W-1:0] t,
                                                input logic [NUM_TAGS-1:0] ex);
      logic [TAG_W-1:0] res;
      logic             hit;
      res = t;
      hit = 1'b0;
      for (int k = 1; k <= NUM_TAGS; k++) begin
         if (!hit && !ex[TAG_W'(32'(t) + k)]) begin
            res = TAG_W'(32'(t) + k);
            hit = 1'b1;
         end
      end
      return res;
   endfunction

   logic [TAG_W-1:0] walk;
   logic             hit0;

   always_comb begin
      walk = start_i;
      hit0 = 1'b0;
      if (&excl_i) begin
         tag_o = '0;
      end else if (offset_i == '0) begin
         for (int k = 0; k < NUM_TAGS; k++) begin
            if (!hit0 && !excl_i[TAG_W'(32'(start_i) + k)]) begin
               walk = TAG_W'(32'(start_i) + k);
               hit0 = 1'b1;
            end
         end
         tag_o = walk;
      end else begin
         for (int a = 1; a <= MAX_OFF; a++) begin
            if (a <= int'(offset_i)) walk = next_ok(walk, excl_i);
         end
         tag_o = walk;
      end
   end
endmodule

// File: rtl/tag_randomizer.sv
module tag_randomizer #(
   parameter int unsigned        PTR_W    = 64,
   parameter int unsigned        TAG_LSB  = 56,
   parameter int unsigned        TAG_W    = 4,
   parameter int unsigned        SEED_W   = 16,
   parameter int unsigned        SEED_LSB = 8,
   parameter int unsigned        STEPS    = 4,
   parameter logic [SEED_W-1:0]  TAPS     = rtg_pkg::RTG_TAPS_DEFAULT,
   parameter logic [SEED_W-1:0]  SEED_SUB = rtg_pkg::RTG_SUB_DEFAULT,
   localparam int unsigned       NUM_TAGS = 1 << TAG_W,
   localparam int unsigned       STATE_W  = SEED_LSB + SEED_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_i,
   input  logic [PTR_W-1:0]      ptr_i,
   input  logic [NUM_TAGS-1:0]   req_excl_i,
   input  logic [NUM_TAGS-1:0]   glob_excl_i,
   input  logic                  rand_mode_i,
   input  logic [TAG_W-1:0]      start_i,
   input  logic [SEED_W-1:0]     seed_i,
   output logic [PTR_W-1:0]      ptr_o,
   output logic [STATE_W-1:0]    state_o,
   output logic                  done_o
);
   localparam logic [PTR_W-1:0] TAG_FIELD = PTR_W'({TAG_W{1'b1}}) << TAG_LSB;
   localparam logic [PTR_W-1:0] KEEP_MASK = ~TAG_FIELD;

   initial begin
      if (TAG_LSB + TAG_W > PTR_W)  $error("tag field exceeds pointer width");
      if (SEED_LSB < TAG_W)         $error("seed field overlaps tag field");
      if (STEPS < 1 || STEPS > 6)   $error("STEPS out of supported range");
      if (SEED_SUB == '0)           $error("substitute seed must be non-zero");
      if (!TAPS[0])                 $error("tap 0 required for a reversible LFSR");
   end

   logic [NUM_TAGS-1:0] excl;
   logic [SEED_W-1:0]   seed_eff, seed_next;
   logic [STEPS-1:0]    offset;
   logic [TAG_W-1:0]    tag;
   logic [PTR_W-1:0]    ptr_ins;
   logic [STATE_W-1:0]  state_next;

   assign excl     = req_excl_i | glob_excl_i;
   assign seed_eff = (rand_mode_i && seed_i == '0) ? SEED_SUB : seed_i;

   rtg_lfsr #(.SEED_W(SEED_W), .STEPS(STEPS), .TAPS(TAPS)) i_lfsr (
      .seed_i (seed_eff),
      .seed_o (seed_next),
      .bits_o (offset)
   );

   rtg_pick #(.TAG_W(TAG_W), .OFF_W(STEPS)) i_pick (
      .start_i  (start_i),
      .offset_i (offset),
      .excl_i   (excl),
      .tag_o    (tag)
   );

   assign ptr_ins = (ptr_i & KEEP_MASK) | (PTR_W'(tag) << TAG_LSB);

   always_comb begin
      state_next                       = '0;
      state_next[TAG_W-1:0]            = tag;
      state_next[SEED_LSB +: SEED_W]   = seed_next;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         ptr_o   <= '0;
         state_o <= '0;
      end else begin
         done_o <= req_i;
         if (req_i) begin
            ptr_o   <= ptr_ins;
            state_o <= state_next;
         end
      end
   end

   // ---------------- checks ----------------
   logic [NUM_TAGS-1:0] chk_excl;
   logic [PTR_W-1:0]    chk_ptr;
   logic                chk_rand;
   logic [TAG_W-1:0]    out_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_excl <= '0;
         chk_ptr  <= '0;
         chk_rand <= 1'b0;
      end else if (req_i) begin
         chk_excl <= req_excl_i | glob_excl_i;
         chk_ptr  <= ptr_i;
         chk_rand <= rand_mode_i;
      end
   end

   assign out_tag = ptr_o[TAG_LSB +: TAG_W];

   assert_tag_allowed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !(&chk_excl)) |-> !chk_excl[out_tag]);

   assert_all_excl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (&chk_excl)) |-> out_tag == '0);

   assert_state_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> state_o[TAG_W-1:0] == out_tag);

   assert_ptr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((ptr_o ^ chk_ptr) & KEEP_MASK) == '0);

   assert_seed_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && chk_rand) |-> state_o[SEED_LSB +: SEED_W] != '0);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(ptr_o) && $stable(state_o) && !done_o));
endmodule

// File: tb/test_tag_randomizer.sv
module test_tag_randomizer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [63:0] ptr_i = '0;
   logic [15:0] req_excl_i = '0;
   logic [15:0] glob_excl_i = '0;
   logic        rand_mode_i = 1'b0;
   logic [3:0]  start_i = '0;
   logic [15:0] seed_i = '0;
   logic [63:0] ptr_o;
   logic [23:0] state_o;
   logic        done_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   tag_randomizer i_tag_randomizer (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ptr_i(ptr_i),
      .req_excl_i(req_excl_i), .glob_excl_i(glob_excl_i),
      .rand_mode_i(rand_mode_i), .start_i(start_i), .seed_i(seed_i),
      .ptr_o(ptr_o), .state_o(state_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string rq, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [3:0] m_choose(input logic [3:0] st, input logic [3:0] off,
                                           input logic [15:0] ex);
      logic [3:0] t = st;
      if (ex == 16'hffff) return 4'd0;
      if (off == 0) begin
         while (ex[t]) t = t + 4'd1;
      end else begin
         for (int i = 0; i < int'(off); i++) begin
            t = t + 4'd1;
            while (ex[t]) t = t + 4'd1;
         end
      end
      return t;
   endfunction

   // Applies one request and checks result, strobe and hold.
   task automatic apply(input logic [63:0] p, input logic [15:0] rx, input logic [15:0] gx,
                        input logic rm, input logic [3:0] st, input logic [15:0] sd,
                        input string rq);
      logic [15:0] s;
      logic [3:0]  off, tg;
      logic        fb;
      logic [63:0] ep;
      logic [23:0] es;
      s = (rm && sd == 16'h0) ? 16'h0001 : sd;
      for (int k = 0; k < 4; k++) begin
         fb = s[5] ^ s[3] ^ s[2] ^ s[0];
         off[k] = fb;
         s = {fb, s[15:1]};
      end
      tg = m_choose(st, off, rx | gx);
      ep = p;
      ep[59:56] = tg;
      es = {s, 4'h0, tg};
      @(negedge clk);
      ptr_i = p; req_excl_i = rx; glob_excl_i = gx; rand_mode_i = rm;
      start_i = st; seed_i = sd; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      ptr_i = ~p; seed_i = ~sd;
      check(done_o === 1'b1, {rq, " R9 done"}, 64'(done_o), 64'd1);
      check(ptr_o === ep, {rq, " ptr"}, ptr_o, ep);
      check(state_o === es, {rq, " state"}, 64'(state_o), 64'(es));
      @(negedge clk);
      check(done_o === 1'b0, {rq, " R9 done drop"}, 64'(done_o), 64'd0);
      check(ptr_o === ep && state_o === es, {rq, " R9 hold"}, ptr_o, ep);
   endtask

   task automatic t_reset;   // R10
      check(done_o === 1'b0 && ptr_o === '0 && state_o === '0, "R10 reset",
            ptr_o | 64'(state_o) | 64'(done_o), 64'd0);
   endtask

   task automatic t_stepping;   // R2 R6 R3
      apply(64'h0123_4567_89AB_CDEF, 16'h0, 16'h0, 1'b0, 4'd3, 16'hACE1, "R2 R6 seed ACE1");
      apply(64'hFFFF_0000_FFFF_0000, 16'h0, 16'h0, 1'b0, 4'd15, 16'h1234, "R6 wrap seed 1234");
      apply(64'h0, 16'h0, 16'h0, 1'b1, 4'd7, 16'hBEEF, "R2 R3 seed BEEF");
   endtask

   task automatic t_union;   // R1
      apply(64'hDEAD_BEEF_0000_1111, 16'h00F0, 16'h0F00, 1'b0, 4'd4, 16'h5A5A, "R1 union a");
      apply(64'hDEAD_BEEF_0000_1111, 16'hAAAA, 16'h5554, 1'b0, 4'd9, 16'h00FF, "R1 only 0 allowed");
      apply(64'h1, 16'h7FFF, 16'h0, 1'b0, 4'd2, 16'h8001, "R1 only 15 allowed");
   endtask

   task automatic t_all;   // R4
      apply(64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 16'hFFFF, 1'b0, 4'd6, 16'h1357, "R4 all excluded");
   endtask

   task automatic t_zero_off;   // R5 (zero seed, random mode off: offset 0)
      apply(64'h0, 16'h0060, 16'h0, 1'b0, 4'd5, 16'h0, "R5 skip 5 6");
      apply(64'h0, 16'h8000, 16'h0, 1'b0, 4'd15, 16'h0, "R5 wrap to 0");
      apply(64'h0, 16'hC000, 16'h0001, 1'b0, 4'd14, 16'h0, "R5 wrap to 1");
      apply(64'h0, 16'h0, 16'h0, 1'b0, 4'd11, 16'h0, "R5 R7 start kept");
   endtask

   task automatic t_zero_seed;   // R7
      apply(64'h55, 16'h0, 16'h0, 1'b1, 4'd0, 16'h0, "R7 substitute seed");
      apply(64'h55, 16'h0010, 16'h0, 1'b1, 4'd8, 16'h0, "R7 substitute with excl");
   endtask

   task automatic t_ptr;   // R8
      apply(64'hF0F0_F0F0_F0F0_F0F0, 16'h0, 16'h0, 1'b0, 4'd1, 16'h2468, "R8 pattern a");
      apply(64'h0F0F_0F0F_0F0F_0F0F, 16'h0, 16'h0, 1'b0, 4'd12, 16'hFFFF, "R8 pattern b");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stepping();
      t_union();
      t_all();
      t_zero_off();
      t_zero_seed();
      t_ptr();
      for (int i = 0; i < 8; i++)
         apply({16'h1234, 48'(i) * 48'h0102_0304_0506}, 16'(i * 16'h0111), 16'h0, 1'(i),
               4'(i * 3), 16'(16'h1F2E + i * 16'h0707), "R1 R6 sweep");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule